// File: doc/BRIEF.md
# SPI Master Shift Engine with Doze Pause and Abortive Stop

This block is a single-slave SPI master for mode 0 (clock idles low, data sampled on the rising clock edge and changed on the falling edge). A character of eight bits is moved out on MOSI most significant bit first while the same number of bits is collected from MISO. The serial clock is derived from the system clock by a programmable divider. A one-cycle start request, accepted while the engine is idle, loads the transmit byte and lowers chip-select. The busy output stays high until the character has completed, at which point a one-cycle done pulse marks the new receive byte.

Two low-power requests shape the engine's behaviour. A doze request only takes effect when the doze-enable configuration bit is set. It never cuts a character short: the character in flight runs to its end, and then no new character is accepted until the request is withdrawn. The received byte and the configuration are unchanged when the request is withdrawn, so work carries on from the same point. A stop request is destructive. On the next clock edge the transfer is thrown away, the shift register and bit position are cleared, and chip-select and the serial clock go back to their idle levels. When stop is released the engine sits in idle and does not continue the old character. The divider and doze-enable settings survive the stop.

Top module: `spi_lp_master`

## Requirements
- R1: While reset is held, busy=0, done=0, cs_n=1, sck=0, mosi=0 and rx_data=0.
- R2: A start pulse taken while the engine is idle, with no stop request and no active doze, makes busy=1 and cs_n=0 from the next cycle. A start pulse that arrives while busy=1 is ignored, and the running character keeps its data.
- R3: In mode 0, MOSI carries tx_data most significant bit first and is stable while sck is high. MISO is sampled on each rising sck edge, with the first sampled bit becoming bit 7 of rx_data. Exactly 8 rising sck edges occur per character, and done is a single-cycle pulse.
- R4: Each sck half period lasts cfg_div+1 clock cycles. Done is seen 16*(cfg_div+1) cycles after the edge that accepts start, and busy falls and cs_n rises at the same time. When busy=0, sck=0 and cs_n=1.
- R5: If doze_req=1 and the doze-enable bit is set, a character already in progress completes with normal timing and data. While this state lasts, start pulses are ignored and rx_data is unchanged.
- R6: Once doze_req is released, the next start is accepted and runs with the divider setting held from before the doze.
- R7: With the doze-enable bit clear, doze_req has no effect, and a start pulse begins a transfer as usual.
- R8: One cycle after stop_req is asserted during a transfer, busy=0, cs_n=1, sck=0 and mosi=0. No done pulse is produced for the aborted character, and rx_data keeps the last completed value.
- R9: While stop_req=1, start pulses are ignored and busy stays 0.
- R10: After stop_req is released, a new transfer starts from the first bit and delivers a complete, correct character. Nothing of the aborted transfer is carried into it.
- R11: A configuration write (cfg_we=1) is ignored while busy=1 or stop_req=1. The divider and doze-enable values are kept through a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_div | input | 8 | Divider value to write; half period = value+1 cycles |
| cfg_doze_en | input | 1 | Doze-enable bit value to write |
| start | input | 1 | Single-cycle request to send one character |
| tx_data | input | 8 | Byte to transmit, taken when start is accepted |
| doze_req | input | 1 | Low-power doze request (graceful pause) |
| stop_req | input | 1 | Low-power stop request (abort and reset to idle) |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | High while a character is being transferred |
| done | output | 1 | One-cycle pulse when a character completes |
| rx_data | output | 8 | Last completed received byte |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low slave select |

## Verification
The hardest state to reach from the ports is a stop that lands in the middle of a character, on a divider setting that has to outlive it. The stimulus first loads a slow divider. It starts a character and lets it run several half periods, then raises stop. While stop is still high it tries both a start and a configuration write with a fast divider. After release, a fresh character must take the slow-divider cycle count, carry a full eight-bit receive byte and produce exactly one done pulse. The doze case is brought about the same way: the request is raised part way through a character, so that the character's completion and the blocked start that follows are both observed.

// File: rtl/spi_lp_pkg.sv
package spi_lp_pkg;

  typedef enum logic [0:0] {
    ENG_IDLE = 1'b0,
    ENG_XFER = 1'b1
  } eng_state_t;

endpackage

// File: rtl/spi_lp_cfg.sv
module spi_lp_cfg #(
  parameter int DIV_W   = 8,
  parameter int RST_DIV = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             lock,
  input  logic [DIV_W-1:0] div_in,
  input  logic             dz_in,
  output logic [DIV_W-1:0] div_q,
  output logic             dz_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= DIV_W'(RST_DIV);
      dz_q  <= 1'b0;
    end else if (we && !lock) begin
      div_q <= div_in;
      dz_q  <= dz_in;
    end
  end

  // R11: settings frozen while locked by busy or stop
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    lock |=> ($stable(div_q) && $stable(dz_q)));

endmodule

// File: rtl/spi_lp_sckgen.sv
module spi_lp_sckgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == div) cnt <= '0;
      else            cnt <= cnt + 1'b1;
    end
  end

  // R4: count never passes the programmed half period while running
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= div));

endmodule

// File: rtl/spi_lp_shift.sv
module spi_lp_shift
  import spi_lp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stop,
  input  logic         halt,
  input  logic         start,
  input  logic [W-1:0] tx,
  input  logic         miso,
  input  logic         tick,
  output logic         load,
  output logic         run,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx,
  output logic         sck,
  output logic         mosi,
  output logic         cs_n
);

  localparam int BCW = (W > 2) ? $clog2(W) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(W - 1);

  eng_state_t     state;
  logic [W-1:0]   shreg;
  logic           samp;
  logic [BCW-1:0] bitcnt;

  assign load = start && (state == ENG_IDLE) && !halt && !stop;
  assign run  = (state == ENG_XFER) && !stop;
  assign mosi = shreg[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ENG_IDLE;
      shreg  <= '0;
      samp   <= 1'b0;
      bitcnt <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      rx     <= '0;
      sck    <= 1'b0;
      cs_n   <= 1'b1;
    end else begin
      done <= 1'b0;
      if (stop) begin
        state  <= ENG_IDLE;
        shreg  <= '0;
        samp   <= 1'b0;
        bitcnt <= '0;
        busy   <= 1'b0;
        sck    <= 1'b0;
        cs_n   <= 1'b1;
      end else begin
        case (state)
          ENG_IDLE: begin
            if (load) begin
              shreg  <= tx;
              bitcnt <= '0;
              sck    <= 1'b0;
              busy   <= 1'b1;
              cs_n   <= 1'b0;
              state  <= ENG_XFER;
            end
          end
          ENG_XFER: begin
            if (tick) begin
              if (!sck) begin
                sck  <= 1'b1;
                samp <= miso;
              end else begin
                sck   <= 1'b0;
                shreg <= {shreg[W-2:0], samp};
                if (bitcnt == LAST_BIT) begin
                  rx     <= {shreg[W-2:0], samp};
                  done   <= 1'b1;
                  busy   <= 1'b0;
                  cs_n   <= 1'b1;
                  bitcnt <= '0;
                  state  <= ENG_IDLE;
                end else begin
                  bitcnt <= bitcnt + 1'b1;
                end
              end
            end
          end
          default: state <= ENG_IDLE;
        endcase
      end
    end
  end

  // R8: a stop request clears the link on the next edge, without done
  a_r8_stop_abort: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!busy && cs_n && !sck && !mosi && !done));

  // R9: no transfer can begin while stop is held
  a_r9_start_blocked_in_stop: assert property (@(posedge clk) disable iff (rst)
    stop |=> !busy);

  // R5: an active doze keeps an idle engine idle
  a_r5_doze_blocks_start: assert property (@(posedge clk) disable iff (rst)
    (halt && !busy && !stop) |=> !busy);

  // R2: busy rises only after a start request
  a_r2_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R3: done lasts exactly one cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: serial lines at idle levels whenever not busy
  a_r4_idle_lines: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sck && cs_n));

  // R3: MOSI holds while the clock is high
  a_r3_mosi_hold_high: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/spi_lp_master.sv
module spi_lp_master #(
  parameter int W       = 8,
  parameter int DIV_W   = 8,
  parameter int RST_DIV = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_doze_en,
  input  logic             start,
  input  logic [W-1:0]     tx_data,
  input  logic             doze_req,
  input  logic             stop_req,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     rx_data,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n
);

  logic [DIV_W-1:0] div_q;
  logic             dz_q;
  logic             halt;
  logic             tick;
  logic             load;
  logic             run;
  logic             cfg_lock;

  assign halt     = doze_req && dz_q;
  assign cfg_lock = busy || stop_req;

  spi_lp_cfg #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) cfg_i (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .lock   (cfg_lock),
    .div_in (cfg_div),
    .dz_in  (cfg_doze_en),
    .div_q  (div_q),
    .dz_q   (dz_q)
  );

  spi_lp_sckgen #(.DIV_W(DIV_W)) sckgen_i (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .clr  (load || stop_req),
    .div  (div_q),
    .tick (tick)
  );

  spi_lp_shift #(.W(W)) shift_i (
    .clk   (clk),
    .rst   (rst),
    .stop  (stop_req),
    .halt  (halt),
    .start (start),
    .tx    (tx_data),
    .miso  (miso),
    .tick  (tick),
    .load  (load),
    .run   (run),
    .busy  (busy),
    .done  (done),
    .rx    (rx_data),
    .sck   (sck),
    .mosi  (mosi),
    .cs_n  (cs_n)
  );

endmodule

// File: tb/spi_lp_master_tb_top.sv
`timescale 1ns/1ps
module spi_lp_master_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_div = 8'd0;
  logic       cfg_doze_en = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       doze_req = 1'b0;
  logic       stop_req = 1'b0;
  logic       miso;
  logic       busy, done, sck, mosi, cs_n;
  logic [7:0] rx_data;

  int errs = 0;
  int checks = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  spi_lp_master dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_doze_en(cfg_doze_en), .start(start), .tx_data(tx_data),
    .doze_req(doze_req), .stop_req(stop_req), .miso(miso),
    .busy(busy), .done(done), .rx_data(rx_data), .sck(sck),
    .mosi(mosi), .cs_n(cs_n)
  );

  // slave model and observers
  int         rises = 0;
  int         falls = 0;
  int         falls_base = 0;
  int         rises_base = 0;
  int         done_cnt = 0;
  logic [7:0] slave_byte = 8'd0;
  logic [7:0] cap = 8'd0;
  int         idx;

  always @(posedge sck) begin
    rises = rises + 1;
    cap   = {cap[6:0], mosi};
  end
  always @(negedge sck) falls = falls + 1;
  always @(posedge clk) if (done === 1'b1) done_cnt = done_cnt + 1;

  assign idx  = falls - falls_base;
  assign miso = (idx >= 0 && idx < 8) ? slave_byte[7 - idx] : 1'b0;

  localparam logic [23:0] VEC [4] = '{
    {8'd0, 8'hA5, 8'h3C},
    {8'd1, 8'h81, 8'hC3},
    {8'd3, 8'h5A, 8'hFF},
    {8'd2, 8'h00, 8'h96}
  };

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] d, input logic dz);
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = d; cfg_doze_en = dz;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  logic b_after, c_after;

  // mode 0: none, 1: poke start and config mid-character, 2: raise doze mid-character
  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] slv,
                          input int mode, output int cyc);
    @(negedge clk);
    slave_byte = slv;
    falls_base = falls;
    rises_base = rises;
    tx_data = tx;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    b_after = busy; c_after = cs_n;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (mode == 1 && cyc == 5) begin
        start = 1'b1; tx_data = 8'h11; cfg_we = 1'b1; cfg_div = 8'd6;
      end else if (mode == 1 && cyc == 6) begin
        start = 1'b0; cfg_we = 1'b0;
      end
      if (mode == 2 && cyc == 5) doze_req = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R4 watchdog actual=hung expected=completion");
    finish_up();
  end

  initial begin
    int cyc;
    int dc;
    logic [7:0] keep;

    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 busy/done in reset", {busy, done}, 0);
    chk(cs_n == 1 && sck == 0 && mosi == 0, "R1 lines in reset", {cs_n, sck, mosi}, 3'b100);
    chk(rx_data == 0, "R1 rx_data in reset", rx_data, 0);
    @(negedge clk); rst = 1'b0;

    // table of transfers
    for (int i = 0; i < 4; i++) begin
      cfg_write(VEC[i][23:16], 1'b0);
      dc = done_cnt;
      run_xfer(VEC[i][15:8], VEC[i][7:0], 0, cyc);
      chk(b_after == 1 && c_after == 0, "R2 busy and cs_n after start", {b_after, c_after}, 2'b10);
      chk(rx_data == VEC[i][7:0], "R3 received byte", rx_data, VEC[i][7:0]);
      chk(cap == VEC[i][15:8], "R3 transmitted byte MSB first", cap, VEC[i][15:8]);
      chk(rises - rises_base == 8, "R3 rising sck edges", rises - rises_base, 8);
      chk(cyc == 16 * (VEC[i][23:16] + 1), "R4 character duration", cyc, 16 * (VEC[i][23:16] + 1));
      @(negedge clk);
      chk(done == 0 && done_cnt - dc == 1, "R3 single done pulse", done_cnt - dc, 1);
      chk(busy == 0 && cs_n == 1 && sck == 0, "R4 idle after done", {busy, cs_n, sck}, 3'b010);
    end

    // start and config write while busy are ignored
    cfg_write(8'd1, 1'b0);
    run_xfer(8'hC6, 8'h4D, 1, cyc);
    chk(cap == 8'hC6, "R2 data kept despite start while busy", cap, 8'hC6);
    chk(cyc == 32, "R11 divider write while busy ignored", cyc, 32);
    run_xfer(8'h12, 8'h34, 0, cyc);
    chk(cyc == 32, "R11 divider still held on next character", cyc, 32);

    // doze with enable set, raised mid-character
    cfg_write(8'd1, 1'b1);
    run_xfer(8'h9C, 8'h65, 2, cyc);
    chk(rx_data == 8'h65 && cyc == 32, "R5 character completes under doze", rx_data, 8'h65);
    keep = rx_data;
    @(negedge clk); start = 1'b1; tx_data = 8'hEE;
    @(posedge clk); @(negedge clk); start = 1'b0;
    chk(busy == 0 && cs_n == 1, "R5 start ignored in doze", {busy, cs_n}, 2'b01);
    repeat (10) @(negedge clk);
    chk(busy == 0 && rx_data == keep, "R5 rx held in doze", rx_data, keep);
    doze_req = 1'b0;
    run_xfer(8'h2B, 8'hD4, 0, cyc);
    chk(rx_data == 8'hD4 && cap == 8'h2B, "R6 transfer after doze", rx_data, 8'hD4);
    chk(cyc == 32, "R6 divider kept across doze", cyc, 32);

    // doze with enable clear
    cfg_write(8'd1, 1'b0);
    doze_req = 1'b1;
    run_xfer(8'h77, 8'h18, 0, cyc);
    chk(b_after == 1, "R7 start accepted in doze without enable", b_after, 1);
    chk(rx_data == 8'h18 && cyc == 32, "R7 transfer normal", rx_data, 8'h18);
    doze_req = 1'b0;

    // stop in the middle of a character
    cfg_write(8'd3, 1'b0);
    keep = rx_data;
    dc = done_cnt;
    @(negedge clk);
    slave_byte = 8'hAA; falls_base = falls; tx_data = 8'hF0; start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    repeat (22) @(negedge clk);
    chk(busy == 1 && sck == 1, "R8 mid-character before stop", {busy, sck}, 2'b11);
    stop_req = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(busy == 0 && cs_n == 1 && sck == 0 && mosi == 0, "R8 abort on stop",
        {busy, cs_n, sck, mosi}, 4'b0100);
    start = 1'b1; tx_data = 8'h55; cfg_we = 1'b1; cfg_div = 8'd0;
    @(posedge clk); @(negedge clk);
    start = 1'b0; cfg_we = 1'b0;
    chk(busy == 0 && cs_n == 1, "R9 start ignored in stop", {busy, cs_n}, 2'b01);
    repeat (3) @(negedge clk);
    stop_req = 1'b0;
    @(negedge clk);
    chk(done_cnt == dc, "R8 no done for aborted character", done_cnt - dc, 0);
    chk(rx_data == keep, "R8 rx keeps last completed byte", rx_data, keep);
    chk(busy == 0, "R10 idle after stop release", busy, 0);
    run_xfer(8'h3E, 8'h71, 0, cyc);
    chk(rx_data == 8'h71 && cap == 8'h3E, "R10 fresh full character after stop", rx_data, 8'h71);
    chk(rises - rises_base == 8, "R10 eight clocks after stop", rises - rises_base, 8);
    chk(cyc == 64, "R11 divider held through stop", cyc, 64);

    finish_up();
  end

endmodule